// File: doc/BRIEF.md
# UART Transmit Queue with DMA Burst Requester

This block is the transmit-side byte queue of a UART together with the logic that asks a DMA engine for data. A DMA write port stores bytes into a 128-entry FIFO. The serial shifter removes them one at a time through a pop port that presents the head byte combinationally. A 2-bit trigger code sets a fill threshold. When the FIFO holds no more bytes than that threshold, the block requests a burst. The advertised burst length is exactly the space left above the threshold, so one complete burst refills the queue.

Software arms a block transfer with a start pulse and an item count. The block then counts the bytes accepted in each burst and the bursts completed in the current transfer. It pulses a done strobe at the end of each burst and at the end of the transfer. When fewer bytes remain in the transfer than a full burst would carry, the final burst is shortened to the remaining count. Two sticky error flags report a pop attempted on an empty queue and a write dropped because the queue was full. Both the asynchronous reset and a synchronous clear input return the block to its empty, idle state.

Top module: `uart_txq_dma`

## Requirements
- R1: Bytes leave through the pop port in the order they were written. `level_o` equals the number of bytes stored. `pop_valid_o` is high exactly when `level_o` is nonzero, and `pop_data_o` shows the oldest byte.
- R2: The trigger code sets the threshold: 0 gives 0, 1 gives DEPTH/8 (16), 2 gives DEPTH/4 (32), and 3 gives DEPTH/2 (64). The full burst length is DEPTH minus the threshold: 128, 112, 96 or 64.
- R3: `dma_req_o` is high when three conditions hold: bytes remain in the armed transfer, no burst is in progress, and `level_o` is at or below the threshold. It is low from the cycle after the first byte of a burst is accepted until that burst ends. It stays low when the transfer size is zero.
- R4: Only a stored write counts toward a burst, and only while a request or a burst is pending. When the burst's final byte is stored, `burst_done_o` is high for exactly the following cycle.
- R5: `block_done_o` is high for one cycle, in the cycle after the transfer's last byte is stored, and it coincides with a `burst_done_o`. `bursts_o` counts the bursts completed since the transfer was armed. A 448-byte transfer takes 4 bursts with code 1 and 7 bursts with code 3.
- R6: When fewer bytes remain in the transfer than the full burst length, `burst_len_o` and the burst itself are shortened to the remaining count.
- R7: A pop while the FIFO is empty changes nothing in the queue and sets `underflow_o`. The flag stays set until a reset or a clear.
- R8: A write while the FIFO is full, with no pop in the same cycle, is dropped and sets `overflow_o`. The flag stays set until a reset or a clear.
- R9: A write and a pop in the same cycle on a full FIFO are both performed: the level stays at DEPTH and no overflow is flagged. On an empty FIFO the write is stored, the level becomes 1, and underflow is flagged.
- R10: `rst_ni` low, or `fifo_clr_i` high at a clock edge, empties the FIFO, clears both flags, cancels the transfer and any burst, and zeroes `bursts_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_clr_i | input | 1 | Synchronous clear of queue, counters and flags |
| trig_code_i | input | 2 | Threshold select code |
| blk_start_i | input | 1 | Arms a transfer of `blk_size_i` bytes |
| blk_size_i | input | BLK_W (12) | Transfer size in bytes |
| wr_valid_i | input | 1 | DMA write strobe |
| wr_data_i | input | DATA_W (8) | DMA write byte |
| pop_i | input | 1 | Shifter takes the head byte |
| pop_data_o | output | DATA_W (8) | Head byte |
| pop_valid_o | output | 1 | Queue not empty |
| level_o | output | 8 | Bytes stored |
| dma_req_o | output | 1 | Burst request |
| burst_len_o | output | 8 | Length of the requested burst |
| burst_done_o | output | 1 | One-cycle end-of-burst strobe |
| block_done_o | output | 1 | One-cycle end-of-transfer strobe |
| bursts_o | output | BLK_W (12) | Bursts completed in the current transfer |
| overflow_o | output | 1 | Sticky dropped-write flag |
| underflow_o | output | 1 | Sticky empty-pop flag |

## Verification
The bench builds the block with its defaults: DEPTH 128, DATA_W 8 and BLK_W 12. At these values the full-scale thresholds are in range, a 448-byte transfer can be replayed with codes 1 and 3 and yield 4 and 7 bursts, and the transfer size field is wide enough for transfers that need a shortened final burst. With a 128-entry queue, both the full and empty boundaries can be reached by direct filling and draining, so dropped writes and simultaneous write-and-pop can be exercised at each edge.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

  typedef enum logic [1:0] {
    TRIG_EMPTY   = 2'd0,
    TRIG_EIGHTH  = 2'd1,
    TRIG_QUARTER = 2'd2,
    TRIG_HALF    = 2'd3
  } trig_e;

  function automatic int unsigned wm_level(input logic [1:0] code, input int unsigned depth);
    case (trig_e'(code))
      TRIG_EMPTY:   return 0;
      TRIG_EIGHTH:  return depth / 8;
      TRIG_QUARTER: return depth / 4;
      default:      return depth / 2;
    endcase
  endfunction

endpackage

// File: rtl/uart_txq_fifo.sv
module uart_txq_fifo #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              push_o,
  output logic              ovf_o,
  output logic              unf_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  level;
  logic              full, empty, do_pop, do_push;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_pop  = pop_i && !empty;
  // a pop in the same cycle frees the slot at full
  assign do_push = wr_valid_i && (!full || do_pop);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf_o  <= 1'b0;
      unf_o  <= 1'b0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf_o  <= 1'b0;
      unf_o  <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (wr_valid_i && !do_push) ovf_o <= 1'b1;
      if (pop_i && empty)         unf_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem[wr_ptr] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_ptr];
  assign level_o   = level;
  assign push_o    = do_push && !clr_i;

endmodule

// File: rtl/uart_txq_burst.sv
module uart_txq_burst #(
  parameter int DEPTH  = 128,
  parameter int BLK_W  = 12,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             blk_start_i,
  input  logic [BLK_W-1:0] blk_size_i,
  input  logic [1:0]       trig_code_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             push_i,
  output logic             req_o,
  output logic [LVL_W-1:0] len_o,
  output logic             burst_done_o,
  output logic             block_done_o,
  output logic [BLK_W-1:0] bursts_o
);

  logic [LVL_W-1:0] wm_lvl, full_len, cur_len, brem, brem_nx;
  logic [BLK_W-1:0] blk_rem;
  logic             in_burst, acc, rem_short;

  assign wm_lvl    = LVL_W'(uart_txq_pkg::wm_level(trig_code_i, DEPTH));
  assign full_len  = LVL_W'(DEPTH) - wm_lvl;
  // BLK_W must be at least LVL_W
  assign rem_short = (blk_rem < BLK_W'(full_len));
  assign cur_len   = rem_short ? LVL_W'(blk_rem) : full_len;
  assign req_o     = (blk_rem != '0) && !in_burst && (level_i <= wm_lvl);
  assign acc       = push_i && (req_o || in_burst);
  assign brem_nx   = in_burst ? brem - 1'b1 : cur_len - 1'b1;
  assign len_o     = cur_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_rem      <= '0;
      brem         <= '0;
      in_burst     <= 1'b0;
      bursts_o     <= '0;
      burst_done_o <= 1'b0;
      block_done_o <= 1'b0;
    end else if (clr_i || blk_start_i) begin
      blk_rem      <= clr_i ? '0 : blk_size_i;
      brem         <= '0;
      in_burst     <= 1'b0;
      bursts_o     <= '0;
      burst_done_o <= 1'b0;
      block_done_o <= 1'b0;
    end else begin
      burst_done_o <= 1'b0;
      block_done_o <= 1'b0;
      if (acc) begin
        blk_rem      <= blk_rem - 1'b1;
        block_done_o <= (blk_rem == BLK_W'(1));
        brem         <= brem_nx;
        if (brem_nx == '0) begin
          in_burst     <= 1'b0;
          burst_done_o <= 1'b1;
          bursts_o     <= bursts_o + 1'b1;
        end else begin
          in_burst <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/uart_txq_dma.sv
module uart_txq_dma #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  parameter int BLK_W  = 12,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_clr_i,
  input  logic [1:0]        trig_code_i,
  input  logic              blk_start_i,
  input  logic [BLK_W-1:0]  blk_size_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              pop_valid_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              dma_req_o,
  output logic [LVL_W-1:0]  burst_len_o,
  output logic              burst_done_o,
  output logic              block_done_o,
  output logic [BLK_W-1:0]  bursts_o,
  output logic              overflow_o,
  output logic              underflow_o
);

  logic push;

  uart_txq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) fifo_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (fifo_clr_i),
    .wr_valid_i(wr_valid_i),
    .wr_data_i (wr_data_i),
    .pop_i     (pop_i),
    .rd_data_o (pop_data_o),
    .level_o   (level_o),
    .push_o    (push),
    .ovf_o     (overflow_o),
    .unf_o     (underflow_o)
  );

  uart_txq_burst #(.DEPTH(DEPTH), .BLK_W(BLK_W)) burst_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (fifo_clr_i),
    .blk_start_i (blk_start_i),
    .blk_size_i  (blk_size_i),
    .trig_code_i (trig_code_i),
    .level_i     (level_o),
    .push_i      (push),
    .req_o       (dma_req_o),
    .len_o       (burst_len_o),
    .burst_done_o(burst_done_o),
    .block_done_o(block_done_o),
    .bursts_o    (bursts_o)
  );

  assign pop_valid_o = (level_o != '0);

endmodule

// File: rtl/uart_txq_dma_chk.sv
module uart_txq_dma_chk #(
  parameter int DEPTH  = 128,
  parameter int BLK_W  = 12,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_clr_i,
  input logic [1:0]       trig_code_i,
  input logic             wr_valid_i,
  input logic             pop_i,
  input logic             pop_valid_o,
  input logic [LVL_W-1:0] level_o,
  input logic             dma_req_o,
  input logic             burst_done_o,
  input logic             block_done_o,
  input logic [BLK_W-1:0] bursts_o,
  input logic             overflow_o,
  input logic             underflow_o
);

  // R3
  req_wm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> level_o <= LVL_W'(uart_txq_pkg::wm_level(trig_code_i, DEPTH)));

  // R4
  burst_done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_done_o |-> $past(wr_valid_i));

  // R5
  block_on_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_done_o |-> burst_done_o);

  // R7
  underflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o && !fifo_clr_i |=> underflow_o);

  // R8
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !fifo_clr_i |=> overflow_o);

  // R1
  pop_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && pop_valid_o && !wr_valid_i && !fifo_clr_i |=> level_o == $past(level_o) - 1'b1);

  // R9
  full_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o == LVL_W'(DEPTH) && pop_i && wr_valid_i && !fifo_clr_i |=> level_o == LVL_W'(DEPTH));

  // R10
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_i |=> level_o == '0 && !overflow_o && !underflow_o && bursts_o == '0);

endmodule

bind uart_txq_dma uart_txq_dma_chk #(.DEPTH(DEPTH), .BLK_W(BLK_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_clr_i  (fifo_clr_i),
  .trig_code_i (trig_code_i),
  .wr_valid_i  (wr_valid_i),
  .pop_i       (pop_i),
  .pop_valid_o (pop_valid_o),
  .level_o     (level_o),
  .dma_req_o   (dma_req_o),
  .burst_done_o(burst_done_o),
  .block_done_o(block_done_o),
  .bursts_o    (bursts_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o)
);

// File: tb/uart_txq_dma_tb_top.sv
module uart_txq_dma_tb_top;

  localparam int DEPTH = 128;
  localparam int BLK_W = 12;

  typedef struct packed {
    logic [1:0]  code;
    logic [11:0] size;
    logic [7:0]  wm;
    logic [7:0]  nb;
    logic [7:0]  first;
    logic [7:0]  last;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 12'd448, 8'd16, 8'd4, 8'd112, 8'd112},
    '{2'd3, 12'd448, 8'd64, 8'd7, 8'd64,  8'd64},
    '{2'd2, 12'd300, 8'd32, 8'd4, 8'd96,  8'd12},
    '{2'd0, 12'd200, 8'd0,  8'd2, 8'd128, 8'd72},
    '{2'd1, 12'd50,  8'd16, 8'd1, 8'd50,  8'd50}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             fifo_clr_i = 1'b0;
  logic [1:0]       trig_code_i = '0;
  logic             blk_start_i = 1'b0;
  logic [BLK_W-1:0] blk_size_i = '0;
  logic             wr_valid_i = 1'b0;
  logic [7:0]       wr_data_i = '0;
  logic             pop_i = 1'b0;
  logic [7:0]       pop_data_o;
  logic             pop_valid_o;
  logic [7:0]       level_o;
  logic             dma_req_o;
  logic [7:0]       burst_len_o;
  logic             burst_done_o;
  logic             block_done_o;
  logic [BLK_W-1:0] bursts_o;
  logic             overflow_o;
  logic             underflow_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  uart_txq_dma dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .fifo_clr_i(fifo_clr_i), .trig_code_i(trig_code_i),
    .blk_start_i(blk_start_i), .blk_size_i(blk_size_i), .wr_valid_i(wr_valid_i),
    .wr_data_i(wr_data_i), .pop_i(pop_i), .pop_data_o(pop_data_o), .pop_valid_o(pop_valid_o),
    .level_o(level_o), .dma_req_o(dma_req_o), .burst_len_o(burst_len_o),
    .burst_done_o(burst_done_o), .block_done_o(block_done_o), .bursts_o(bursts_o),
    .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_q();
    @(negedge clk_i) fifo_clr_i = 1'b1;
    @(negedge clk_i) fifo_clr_i = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int wseq, rseq, nb, first, last, guard, len;
    bit fin;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk(level_o == 0 && !pop_valid_o, "R10", level_o, 0);
    chk(!dma_req_o && bursts_o == 0, "R10", dma_req_o, 0);
    chk(!overflow_o && !underflow_o, "R10", overflow_o + underflow_o, 0);

    // R3 zero-size transfer raises no request
    blk_size_i = '0; blk_start_i = 1'b1;
    @(negedge clk_i) blk_start_i = 1'b0;
    @(negedge clk_i);
    chk(!dma_req_o, "R3", dma_req_o, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      clear_q();
      trig_code_i = VECS[v].code;
      blk_size_i  = VECS[v].size;
      blk_start_i = 1'b1;
      @(negedge clk_i) blk_start_i = 1'b0;
      wseq = 0; rseq = 0; nb = 0; first = 0; last = 0; guard = 0; fin = 0;
      while (!fin && guard < 20000) begin
        guard++;
        if (dma_req_o) begin
          len = int'(burst_len_o);
          if (nb > 0) chk(level_o == VECS[v].wm, "R2", level_o, VECS[v].wm);
          if (nb == 0) first = len;
          last = len;
          nb++;
          for (int i = 0; i < len; i++) begin
            if (i > 0) begin
              chk(!dma_req_o, "R3", dma_req_o, 0);
              chk(!burst_done_o, "R4", burst_done_o, 0);
            end
            wr_valid_i = 1'b1;
            wr_data_i  = 8'(wseq);
            @(negedge clk_i);
            wseq++;
          end
          wr_valid_i = 1'b0;
          chk(burst_done_o, "R4", burst_done_o, 1);
          if (block_done_o) fin = 1;
        end else begin
          chk(pop_valid_o && pop_data_o == 8'(rseq), "R1", pop_data_o, rseq % 256);
          pop_i = 1'b1;
          @(negedge clk_i);
          pop_i = 1'b0;
          rseq++;
        end
      end
      chk(fin, "R5", fin, 1);
      chk(nb == VECS[v].nb, "R5", nb, VECS[v].nb);
      chk(bursts_o == BLK_W'(nb), "R5", bursts_o, nb);
      chk(first == VECS[v].first, "R2", first, VECS[v].first);
      chk(last == VECS[v].last, "R6", last, VECS[v].last);
      @(negedge clk_i);
      chk(!block_done_o && !burst_done_o, "R5", block_done_o, 0);
    end

    // R7 pop on empty
    clear_q();
    pop_i = 1'b1;
    @(negedge clk_i) pop_i = 1'b0;
    chk(underflow_o && level_o == 0, "R7", underflow_o, 1);
    repeat (3) @(negedge clk_i);
    chk(underflow_o, "R7", underflow_o, 1);
    clear_q();
    chk(!underflow_o, "R10", underflow_o, 0);

    // R9 write and pop together on empty
    wr_valid_i = 1'b1; wr_data_i = 8'h5A; pop_i = 1'b1;
    @(negedge clk_i);
    wr_valid_i = 1'b0; pop_i = 1'b0;
    chk(level_o == 1, "R9", level_o, 1);
    chk(underflow_o, "R9", underflow_o, 1);
    chk(pop_data_o == 8'h5A, "R9", pop_data_o, 8'h5A);
    clear_q();

    // fill to full with no transfer armed
    for (int i = 0; i < DEPTH; i++) begin
      wr_valid_i = 1'b1; wr_data_i = 8'(i);
      @(negedge clk_i);
    end
    wr_valid_i = 1'b0;
    chk(level_o == DEPTH, "R1", level_o, DEPTH);
    // R9 write and pop together on full
    wr_valid_i = 1'b1; wr_data_i = 8'(DEPTH); pop_i = 1'b1;
    @(negedge clk_i);
    wr_valid_i = 1'b0; pop_i = 1'b0;
    chk(level_o == DEPTH && !overflow_o, "R9", level_o, DEPTH);
    // R8 dropped write
    wr_valid_i = 1'b1; wr_data_i = 8'hEE;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    chk(overflow_o && level_o == DEPTH, "R8", level_o, DEPTH);
    for (int i = 1; i <= DEPTH; i++) begin
      chk(pop_data_o == 8'(i), "R8", pop_data_o, i % 256);
      pop_i = 1'b1;
      @(negedge clk_i);
      pop_i = 1'b0;
    end
    chk(!pop_valid_o && overflow_o, "R8", pop_valid_o, 0);

    // R10 asynchronous reset clears flags
    pop_i = 1'b1;
    @(negedge clk_i) pop_i = 1'b0;
    #2 rst_ni = 1'b0;
    #1;
    chk(!overflow_o && !underflow_o && level_o == 0, "R10", overflow_o + underflow_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule